// File: doc/BRIEF.md
# Turbo Decoder Iteration Sequencer

This block is the top-level control state machine of a turbo decoder in which one soft-in/soft-out (SISO) engine is shared in time between the two constituent decoders. A frame of received soft symbols arrives on a valid/ready stream. The block hands out a natural-order store address for each accepted symbol. When the frame is complete it runs a fixed number of full iterations. Each full iteration is two half-iterations, and each half-iteration is one start/done handshake with the shared engine.

A half-iteration select tells the engine which constituent decoder it plays in the current half-iteration. The same select sets the read/write roles of the two extrinsic memories and turns interleaved addressing on or off. The block forces the a priori input to zero for the very first half-iteration of each frame. After the last half-iteration it streams out hard-decision read addresses on a second valid/ready stream, in natural order, and then returns to idle for the next frame.

Back-pressure rules. On the input side, a symbol is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` depends only on the block state and never on `in_valid`. On the output side, once `out_valid` rises it stays high, and `out_addr`/`out_last` hold steady, until `out_ready` takes the beat.

Top module: `turbo_iter_seq`

## Requirements
- R1: Right after reset the block is idle: `in_ready`=1, `out_valid`=0, `siso_start`=0, `rdy_str`=0, `rdy_siso`=0.
- R2: In idle and while storing, `in_ready`=1. Each accepted symbol raises `mem_we` in the same cycle. `mem_addr` runs 0,1,…,FRAME_LEN-1 over the accepted symbols of a frame, and gaps in `in_valid` do not advance it. The first accepted symbol in idle acts as the first-data strobe and is stored at address 0.
- R3: `rdy_str` is high exactly in the cycle of the FRAME_LEN-th accepted symbol. From the next cycle, `in_ready`=0 and `mem_we`=0 until the frame has been fully output, even if `in_valid` is high.
- R4: `siso_start` is a one-cycle pulse. It is raised in the first decoding cycle and again in the cycle after each accepted `siso_done` that is not the last. That gives exactly 2×ITERS pulses per frame.
- R5: A `siso_done` that arrives while no half-iteration is in progress (including in the `siso_start` cycle itself) is ignored: it neither advances the sequence nor produces a start.
- R6: The half-iteration select starts low in each frame and alternates on every accepted `siso_done`. Select low: `dec_sel`=0, `ext_rd_sel`=1 (read extrinsic memory 2), `ext_wr_sel`=0 (write memory 1), `interleave_en`=0. Select high: `dec_sel`=1, `ext_rd_sel`=0, `ext_wr_sel`=1, `interleave_en`=1.
- R7: `apri_zero` is high during the first half-iteration of the first iteration of each frame, and low for every later half-iteration.
- R8: `rdy_siso` is high exactly in the cycle the 2×ITERS-th `siso_done` is accepted, and `out_valid` is high from the next cycle.
- R9: The output stream gives `out_addr` 0,1,…,FRAME_LEN-1 (natural order). `out_last`=1 only on the final beat. While `out_valid`=1 and `out_ready`=0, the beat holds.
- R10: In the cycle after the final output beat is taken, the block is idle again: `out_valid`=0, `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received symbol available |
| in_ready | output | 1 | Block takes a symbol this cycle |
| mem_we | output | 1 | Write strobe to received-symbol RAM |
| mem_addr | output | AW | Store address, natural order |
| rdy_str | output | 1 | Frame stored (pulse) |
| siso_start | output | 1 | Start one half-iteration on the shared engine |
| siso_done | input | 1 | Shared engine finished the half-iteration |
| dec_sel | output | 1 | Constituent decoder played: 0 first, 1 second |
| ext_rd_sel | output | 1 | Extrinsic memory read for a priori: 0 mem 1, 1 mem 2 |
| ext_wr_sel | output | 1 | Extrinsic memory written: 0 mem 1, 1 mem 2 |
| interleave_en | output | 1 | Engine uses interleaved addressing |
| apri_zero | output | 1 | Force a priori input to zero |
| rdy_siso | output | 1 | All iterations done (pulse) |
| out_valid | output | 1 | Hard-decision beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | AW | Hard-decision read address, natural order |
| out_last | output | 1 | Final beat of the frame |

## Verification
A wrong frame counter shows up as a skipped or repeated `mem_addr` within one accepted symbol. It also moves `rdy_str` away from the FRAME_LEN-th beat. A wrong half-iteration flag or iteration count is visible at the next `siso_start`, through the memory selects, `interleave_en` and `apri_zero`, or as a wrong number of starts before `rdy_siso`. A stuck control state is visible within a cycle as `in_ready` or `out_valid` being asserted in the wrong phase.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STORE = 2'd1,
    ST_ITER  = 2'd2,
    ST_DRAIN = 2'd3
  } tis_state_e;
endpackage

// File: rtl/tis_idx_counter.sv
// Wrapping frame index: shared by the store phase and the drain phase.
module tis_idx_counter #(
  parameter int LIMIT = 64,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] idx,
  output logic         at_end
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign at_end = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (inc)    idx <= at_end ? '0 : idx + 1'b1;
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !at_end) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/tis_half_tracker.sv
// Tracks the half-iteration flag, iteration index and engine busy state.
module tis_half_tracker #(
  parameter int ITERS = 5,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done,
  output logic          busy,
  output logic          half,
  output logic [IW-1:0] iter_idx,
  output logic          done_acc,
  output logic          final_half
);
  localparam logic [IW-1:0] LAST_IT = IW'(ITERS - 1);

  assign done_acc   = busy && done;
  assign final_half = half && (iter_idx == LAST_IT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      half     <= 1'b0;
      iter_idx <= '0;
    end else begin
      if (start)         busy <= 1'b1;
      else if (done_acc) busy <= 1'b0;
      if (done_acc) begin
        if (final_half) begin
          half     <= 1'b0;
          iter_idx <= '0;
        end else begin
          half <= ~half;
          if (half) iter_idx <= iter_idx + 1'b1;
        end
      end
    end
  end

  // R6
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && !final_half) |=> half != $past(half));
  // R5
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (half == $past(half)) && (iter_idx == $past(iter_idx)));
  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/turbo_iter_seq.sv
module turbo_iter_seq
  import tis_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int ITERS     = 5,
  parameter int AW        = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          rdy_str,
  output logic          siso_start,
  input  logic          siso_done,
  output logic          dec_sel,
  output logic          ext_rd_sel,
  output logic          ext_wr_sel,
  output logic          interleave_en,
  output logic          apri_zero,
  output logic          rdy_siso,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_last
);
  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;

  tis_state_e    state, state_nx;
  logic [AW-1:0] idx;
  logic          at_end, accept, out_fire, busy, half, done_acc, final_half;
  logic [IW-1:0] iter_idx;

  assign in_ready = (state == ST_IDLE) || (state == ST_STORE);
  assign accept   = in_valid && in_ready;
  assign out_valid = (state == ST_DRAIN);
  assign out_fire  = out_valid && out_ready;

  tis_idx_counter #(.LIMIT(FRAME_LEN), .W(AW)) u_idx (
    .clk(clk), .rst_n(rst_n), .inc(accept || out_fire),
    .idx(idx), .at_end(at_end)
  );

  tis_half_tracker #(.ITERS(ITERS), .IW(IW)) u_half (
    .clk(clk), .rst_n(rst_n), .start(siso_start), .done(siso_done),
    .busy(busy), .half(half), .iter_idx(iter_idx),
    .done_acc(done_acc), .final_half(final_half)
  );

  assign mem_we   = accept;
  assign mem_addr = idx;
  assign rdy_str  = accept && at_end;
  assign out_addr = idx;
  assign out_last = out_valid && at_end;

  assign siso_start    = (state == ST_ITER) && !busy;
  assign rdy_siso      = (state == ST_ITER) && done_acc && final_half;
  assign dec_sel       = half;
  assign ext_rd_sel    = ~half;
  assign ext_wr_sel    = half;
  assign interleave_en = half;
  assign apri_zero     = (state == ST_ITER) && !half && (iter_idx == '0);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept)           state_nx = at_end ? ST_ITER : ST_STORE;
      ST_STORE: if (rdy_str)          state_nx = ST_ITER;
      ST_ITER:  if (rdy_siso)         state_nx = ST_DRAIN;
      ST_DRAIN: if (out_fire && at_end) state_nx = ST_IDLE;
      default:                        state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R3
  store_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_str |=> !in_ready);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    siso_start |=> !siso_start);
  // R8
  drain_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_siso |=> out_valid);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr));
  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));
  // R7
  apri_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apri_zero |-> !dec_sel);
endmodule

// File: tb/test_turbo_iter_seq.sv
module test_turbo_iter_seq;
  localparam int N  = 6;
  localparam int IT = 3;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, siso_done = 1'b0, out_ready = 1'b0;
  logic in_ready, mem_we, rdy_str, siso_start, dec_sel, ext_rd_sel, ext_wr_sel;
  logic interleave_en, apri_zero, rdy_siso, out_valid, out_last;
  logic [AW-1:0] mem_addr, out_addr;

  int n_run = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  turbo_iter_seq #(.FRAME_LEN(N), .ITERS(IT)) i_turbo_iter_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .rdy_str(rdy_str),
    .siso_start(siso_start), .siso_done(siso_done), .dec_sel(dec_sel),
    .ext_rd_sel(ext_rd_sel), .ext_wr_sel(ext_wr_sel),
    .interleave_en(interleave_en), .apri_zero(apri_zero),
    .rdy_siso(rdy_siso), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_last(out_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {spurious_done, latency[3:0], in_gap_mask[7:0], out_stall_mask[7:0]}
  localparam logic [20:0] VEC [5] = '{
    {1'b0, 4'd0, 8'h00, 8'h00},
    {1'b1, 4'd2, 8'h24, 8'h00},
    {1'b0, 4'd5, 8'h00, 8'h5A},
    {1'b1, 4'd1, 8'hA5, 8'h33},
    {1'b1, 4'd3, 8'h11, 8'h81}
  };

  task automatic run_frame(input logic [20:0] v);
    int cyc = 0;
    int k = 0;
    logic spur = v[20];
    int lat = int'(v[19:16]);
    // storage phase
    while (k < N) begin
      @(negedge clk);
      in_valid = ~v[8 + (cyc % 8)];
      siso_done = 1'b0; out_ready = 1'b0;
      #1;
      chk("R2 in_ready", int'(in_ready), 1);
      chk("R2 mem_we", int'(mem_we), int'(in_valid));
      if (in_valid) begin
        chk("R2 mem_addr", int'(mem_addr), k);
        chk("R3 rdy_str", int'(rdy_str), int'(k == N - 1));
        k++;
      end else chk("R3 rdy_str idle", int'(rdy_str), 0);
      cyc++;
    end
    // half-iterations; input pushed but must be refused
    for (int h = 0; h < 2 * IT; h++) begin
      @(negedge clk);
      in_valid = 1'b1; siso_done = spur;
      #1;
      chk("R4 siso_start", int'(siso_start), 1);
      chk("R3 in_ready low", int'(in_ready), 0);
      chk("R3 mem_we low", int'(mem_we), 0);
      chk("R6 dec_sel", int'(dec_sel), h % 2);
      chk("R6 ext_rd_sel", int'(ext_rd_sel), 1 - (h % 2));
      chk("R6 ext_wr_sel", int'(ext_wr_sel), h % 2);
      chk("R6 interleave_en", int'(interleave_en), h % 2);
      chk("R7 apri_zero", int'(apri_zero), int'(h == 0));
      chk("R5 rdy_siso", int'(rdy_siso), 0);
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        siso_done = 1'b0;
        #1;
        chk("R4 no start while busy", int'(siso_start), 0);
      end
      @(negedge clk);
      siso_done = 1'b1;
      #1;
      chk("R4 no start at done", int'(siso_start), 0);
      chk("R8 rdy_siso", int'(rdy_siso), int'(h == 2 * IT - 1));
    end
    // drain phase
    k = 0; cyc = 0;
    while (k < N) begin
      @(negedge clk);
      siso_done = 1'b0; in_valid = 1'b0;
      out_ready = ~v[cyc % 8];
      #1;
      chk("R9 out_valid", int'(out_valid), 1);
      chk("R9 out_addr", int'(out_addr), k);
      chk("R9 out_last", int'(out_last), int'(k == N - 1));
      chk("R4 no start in drain", int'(siso_start), 0);
      if (out_ready) k++;
      cyc++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk("R10 out_valid low", int'(out_valid), 0);
    chk("R10 in_ready high", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 siso_start", int'(siso_start), 0);
    chk("R1 rdy_str", int'(rdy_str), 0);
    chk("R1 rdy_siso", int'(rdy_siso), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R5: stray done while idle must not disturb the first frame
    @(negedge clk);
    siso_done = 1'b1;
    #1;
    chk("R5 idle stray done start", int'(siso_start), 0);
    @(negedge clk);
    siso_done = 1'b0;
    #1;
    chk("R2 idle mem_we without valid", int'(mem_we), 0);
    foreach (VEC[i]) run_frame(VEC[i]);
    // directed: reset in the middle of storing restarts the address
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-frame reset in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1;
    #1;
    chk("R2 addr restarts at 0", int'(mem_addr), 0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_frame({1'b0, 4'd0, 8'hFE, 8'h7F});
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule